// File: doc/BRIEF.md
# Link Power Status Interface Controller

This block sits between the PHY core and the link layer. It watches the link layer's power status line and uses it to choose a state for the PHY-to-link interface. It stays in normal operation while the line is active. After a short low period it drops to a reset state. After a long low period it moves to a disabled state. A short low pulse is treated as still active. The interface state comes only from this line. No register-held control bit takes part.

In the reset state the control and data outputs toward the link are forced to zero and link requests are blocked, but the system clock enable stays on. The disabled state also turns the system clock enable off, and hardware reset holds the interface there. When the line is seen high again from either state, an initialization window runs with outputs still at zero, and the interface then returns to normal. If the node reports low-power mode when the wake-up starts from the disabled state, a longer start-up window is used instead.

All time thresholds are parameters counted in clock cycles. The status line passes through a two-flop synchronizer before any decision is made. The block does not touch repeater or arbitration activity on the cable ports.

Top module: `lps_link_ctrl`

## Requirements
- R1: A run of consecutive low samples of the synchronized status input longer than `LOW_RST_CYC` moves `if_state` from normal (3) to reset (1). A shorter low run leaves `if_state` at normal. Encoding: 0 = disabled, 1 = reset, 2 = init, 3 = normal.
- R2: Whenever `if_state` is not normal (reset, init or disabled), the outputs `ctl_out`, `data_out` and `lreq_out` are zero one cycle later. In the reset state `sysclk_en` stays 1.
- R3: A low run that reaches `LOW_DIS_CYC` cycles (with `LOW_DIS_CYC` > `LOW_RST_CYC`) moves the interface to disabled (0), and `sysclk_en` goes to 0 one cycle later.
- R4: While `rst` is high, `if_state` is disabled (0) and `sysclk_en` is 0.
- R5: From reset or disabled, a high synchronized status input starts init (2). Init lasts exactly `INIT_CYC` cycles and is followed by normal (3).
- R6: When leaving disabled while `lowpwr` is high, init lasts exactly `WAKE_CYC` cycles instead of `INIT_CYC`.
- R7: In normal, `ctl_out`, `data_out` and `lreq_out` copy `ctl_core`, `data_core` and `lreq_in` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| lps_in | input | 1 | Asynchronous link power status from the link layer |
| lowpwr | input | 1 | Node is in low-power mode (selects the long start-up window) |
| lreq_in | input | 1 | Link request from the link layer |
| ctl_core | input | CTLW | Control value from the PHY core toward the link |
| data_core | input | DW | Data value from the PHY core toward the link |
| ctl_out | output | CTLW | Registered control output to the link, zero unless normal |
| data_out | output | DW | Registered data output to the link, zero unless normal |
| lreq_out | output | 1 | Link request forwarded to the PHY core, zero unless normal |
| sysclk_en | output | 1 | System clock output enable, low in disabled |
| if_state | output | 2 | Interface state: 0 disabled, 1 reset, 2 init, 3 normal |

## Verification
The bench builds the block with `LOW_RST_CYC`=8, `LOW_DIS_CYC`=40, `INIT_CYC`=5, `WAKE_CYC`=20 and an 8-bit data path. With these values, glitches just under the reset threshold, entry into reset, the long run to disabled and both start-up windows all fit in a few hundred cycles. The init windows are short enough that the bench can count their length cycle by cycle, which tells the normal start-up apart from the low-power one.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    IF_DIS  = 2'd0,
    IF_RST  = 2'd1,
    IF_INIT = 2'd2,
    IF_NORM = 2'd3
  } if_state_t;
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lpc_lowtimer.sv
module lpc_lowtimer #(
  parameter int LOW_RST_CYC = 130,
  parameter int LOW_DIS_CYC = 1300
) (
  input  logic clk,
  input  logic rst,
  input  logic lps_s,
  output logic inactive,
  output logic dis_hit
);
  localparam int CW = $clog2(LOW_DIS_CYC + 1);
  localparam logic [CW-1:0] RST_LIM = CW'(LOW_RST_CYC);
  localparam logic [CW-1:0] DIS_LIM = CW'(LOW_DIS_CYC);

  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || lps_s)            low_cnt_q <= '0;
    else if (low_cnt_q != DIS_LIM) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign inactive = (low_cnt_q > RST_LIM);
  assign dis_hit  = (low_cnt_q == DIS_LIM);

  // R3: the low-time counter never passes its saturation point
  p_sat_r3: assert property (@(posedge clk) disable iff (rst)
    low_cnt_q <= DIS_LIM);

  // R1: a high sample clears the low run
  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    lps_s |=> !inactive && !dis_hit);
endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
  import lpc_pkg::*;
#(
  parameter int INIT_CYC = 16,
  parameter int WAKE_CYC = 100000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lps_s,
  input  logic      inactive,
  input  logic      dis_hit,
  input  logic      lowpwr,
  output if_state_t state
);
  localparam int MAXW = (WAKE_CYC > INIT_CYC) ? WAKE_CYC : INIT_CYC;
  localparam int IW   = $clog2(MAXW + 1);
  localparam logic [IW-1:0] INIT_LD = IW'(INIT_CYC - 1);
  localparam logic [IW-1:0] WAKE_LD = IW'(WAKE_CYC - 1);

  if_state_t     st_q;
  logic [IW-1:0] init_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= IF_DIS;
      init_cnt_q <= '0;
    end else begin
      unique case (st_q)
        IF_NORM: if (inactive) st_q <= IF_RST;
        IF_RST: begin
          if (dis_hit) st_q <= IF_DIS;
          else if (lps_s) begin
            st_q       <= IF_INIT;
            init_cnt_q <= INIT_LD;
          end
        end
        IF_DIS: begin
          if (lps_s) begin
            st_q       <= IF_INIT;
            init_cnt_q <= lowpwr ? WAKE_LD : INIT_LD;
          end
        end
        IF_INIT: begin
          if (inactive)             st_q <= IF_RST;
          else if (init_cnt_q == '0) st_q <= IF_NORM;
          else                      init_cnt_q <= init_cnt_q - 1'b1;
        end
        default: st_q <= IF_DIS;
      endcase
    end
  end

  assign state = st_q;

  // R1: a low run past the reset threshold leaves normal for reset
  p_enter_rst_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == IF_NORM && inactive) |=> st_q == IF_RST);

  // R5: an active input in reset starts init
  p_rst_wake_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == IF_RST && lps_s && !dis_hit) |=> st_q == IF_INIT);

  // R3: a saturated low run in reset lands in disabled
  p_to_dis_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == IF_RST && dis_hit) |=> st_q == IF_DIS);

  // R5: normal is entered only from init
  p_norm_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q != IF_NORM && st_q != IF_INIT) |=> st_q != IF_NORM);
endmodule

// File: rtl/lps_link_ctrl.sv
module lps_link_ctrl
  import lpc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CTLW        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_RST_CYC = 130,
  parameter int LOW_DIS_CYC = 1300,
  parameter int INIT_CYC    = 16,
  parameter int WAKE_CYC    = 100000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lps_in,
  input  logic            lowpwr,
  input  logic            lreq_in,
  input  logic [CTLW-1:0] ctl_core,
  input  logic [DW-1:0]   data_core,
  output logic [CTLW-1:0] ctl_out,
  output logic [DW-1:0]   data_out,
  output logic            lreq_out,
  output logic            sysclk_en,
  output logic [1:0]      if_state
);
  logic      lps_s;
  logic      inactive;
  logic      dis_hit;
  if_state_t st;

  lpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(lps_in), .d_sync(lps_s)
  );

  lpc_lowtimer #(.LOW_RST_CYC(LOW_RST_CYC), .LOW_DIS_CYC(LOW_DIS_CYC)) u_timer (
    .clk(clk), .rst(rst), .lps_s(lps_s), .inactive(inactive), .dis_hit(dis_hit)
  );

  lpc_fsm #(.INIT_CYC(INIT_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk(clk), .rst(rst), .lps_s(lps_s), .inactive(inactive),
    .dis_hit(dis_hit), .lowpwr(lowpwr), .state(st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_out   <= '0;
      data_out  <= '0;
      lreq_out  <= 1'b0;
      sysclk_en <= 1'b0;
    end else begin
      ctl_out   <= (st == IF_NORM) ? ctl_core  : '0;
      data_out  <= (st == IF_NORM) ? data_core : '0;
      lreq_out  <= (st == IF_NORM) && lreq_in;
      sysclk_en <= (st != IF_DIS);
    end
  end

  assign if_state = st;

  // R2: outputs toward the link are quiet outside normal
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st != IF_NORM) |=> (ctl_out == '0 && data_out == '0 && !lreq_out));

  // R2: clock keeps running in the reset state
  p_clk_rst_r2: assert property (@(posedge clk) disable iff (rst)
    (st == IF_RST) |=> sysclk_en);

  // R3: disabled gates the system clock
  p_noclk_r3: assert property (@(posedge clk) disable iff (rst)
    (st == IF_DIS) |=> !sysclk_en);

  // R7: normal passes the core values with one cycle of latency
  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (st == IF_NORM) |=> (ctl_out == $past(ctl_core) && data_out == $past(data_core)));
endmodule

// File: tb/sim_lps_link_ctrl.sv
`timescale 1ns/1ps
module sim_lps_link_ctrl;
  localparam int DW = 8, CTLW = 2;
  localparam int RSTC = 8, DISC = 40, INITC = 5, WAKEC = 20;

  logic clk = 1'b0;
  logic rst, lps_in, lowpwr, lreq_in;
  logic [CTLW-1:0] ctl_core, ctl_out;
  logic [DW-1:0]   data_core, data_out;
  logic lreq_out, sysclk_en;
  logic [1:0] if_state;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lps_link_ctrl #(.DW(DW), .CTLW(CTLW), .LOW_RST_CYC(RSTC), .LOW_DIS_CYC(DISC),
                  .INIT_CYC(INITC), .WAKE_CYC(WAKEC)) u0 (
    .clk(clk), .rst(rst), .lps_in(lps_in), .lowpwr(lowpwr), .lreq_in(lreq_in),
    .ctl_core(ctl_core), .data_core(data_core), .ctl_out(ctl_out),
    .data_out(data_out), .lreq_out(lreq_out), .sysclk_en(sysclk_en),
    .if_state(if_state));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_normal();
    lps_in = 1'b1; lowpwr = 1'b0;
    cyc(60);
  endtask

  task automatic t_reset_state();
    rst = 1'b1; lps_in = 1'b1; cyc(5);
    chk("R4 state in reset", if_state, 0);
    chk("R4 sysclk in reset", sysclk_en, 0);
    rst = 1'b0; cyc(60);
    chk("R5 normal after wake", if_state, 3);
  endtask

  task automatic t_pass();
    ctl_core = 2'b10; data_core = 8'hA5; lreq_in = 1'b1; cyc(2);
    chk("R7 ctl pass", ctl_out, 2'b10);
    chk("R7 data pass", data_out, 8'hA5);
    chk("R7 lreq pass", lreq_out, 1);
    data_core = 8'h3C; cyc(2);
    chk("R7 data follow", data_out, 8'h3C);
  endtask

  task automatic t_glitch();
    bit left = 0;
    lps_in = 1'b0; cyc(RSTC - 2);
    lps_in = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (if_state != 3) left = 1;
    end
    chk("R1 short low keeps normal", left, 0);
  endtask

  task automatic t_reset_entry();
    lps_in = 1'b0; cyc(16);
    chk("R1 reset state", if_state, 1);
    chk("R2 sysclk on in reset", sysclk_en, 1);
    chk("R2 ctl zero", ctl_out, 0);
    chk("R2 data zero", data_out, 0);
    chk("R2 lreq ignored", lreq_out, 0);
  endtask

  task automatic measure_init(input string req, input int exp_len);
    int n = 0;
    lps_in = 1'b1;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (if_state == 2) begin
        n++;
        if (data_out != 0) n = 1000;
      end
    end
    chk(req, n, exp_len);
    chk({req, " ends normal"}, if_state, 3);
  endtask

  task automatic t_disable(input bit lp, input int exp_len);
    lps_in = 1'b0; cyc(50);
    chk("R3 disabled state", if_state, 0);
    chk("R3 sysclk off", sysclk_en, 0);
    chk("R2 data zero in disabled", data_out, 0);
    lowpwr = lp;
    measure_init(lp ? "R6 wake length" : "R5 init length", exp_len);
    lowpwr = 1'b0;
  endtask

  initial begin
    rst = 1'b1; lps_in = 1'b0; lowpwr = 1'b0; lreq_in = 1'b0;
    ctl_core = '0; data_core = '0;
    cyc(3);
    chk("R4 reset out", {ctl_out, data_out, lreq_out}, 0);
    t_reset_state();
    t_pass();
    t_glitch();
    t_reset_entry();
    measure_init("R5 init from reset", INITC);
    t_pass();
    t_disable(1'b0, INITC);
    t_disable(1'b1, WAKEC);
    t_pass();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule